// File: doc/BRIEF.md
# Serial Byte Frame Transmitter

This block turns one 8-bit byte per request into a framed bit stream on a single output wire. The wire rests high. A frame is a low start bit, eight data bits and a high stop bit. Every bit, start and stop included, is held for the same whole number of clock cycles. That number is derived from two parameters: the clock frequency divided by the bit rate. The defaults give 3255 cycles at 125 MHz, close to a 38400 bit/s line.

A producer offers a byte on `data_i` with `valid_i`. The transfer takes place on the rising clock edge where `valid_i` and `ready_o` are both high. At that edge the byte is copied into an internal frame register, together with the data-order select `lsb_first_i`. The frame then plays out without further attention from the producer. The default order sends the most significant bit first. Driving `lsb_first_i` high at acceptance reverses the order.

`busy_o` is high for exactly the length of one frame. `ready_o` is high only while the transmitter is idle. Back-to-back bytes therefore have at least one idle cycle between the end of one stop bit and the next start bit.

Top module: `serial_frame_tx`

## Requirements
- R1: When no frame is in progress (`busy_o` low), `tx_o` is 1.
- R2: On the clock edge after acceptance, `tx_o` goes to 0 and stays 0 for exactly BIT_CYCLES cycles (the start bit). Every following bit also lasts exactly BIT_CYCLES cycles.
- R3: With `lsb_first_i`=0 at acceptance, the eight data bits after the start bit are `data_i[7]` down to `data_i[0]`, in that order.
- R4: With `lsb_first_i`=1 at acceptance, the eight data bits after the start bit are `data_i[0]` up to `data_i[7]`, in that order.
- R5: The tenth bit is a stop bit at 1 lasting BIT_CYCLES cycles. `busy_o` is high for exactly 10*BIT_CYCLES cycles per frame and falls at the end of the stop bit, leaving `tx_o` at 1.
- R6: A byte is accepted only on an edge where `valid_i` and `ready_o` are both high. `ready_o` is low for the whole frame, and `valid_i` asserted during a frame neither starts nor alters a frame.
- R7: Changes on `data_i` or `lsb_first_i` after acceptance have no effect on the frame being sent.
- R8: Asserting `rst_ni` low, including in the middle of a frame, at once forces `tx_o` to 1, `busy_o` to 0 and `ready_o` to 1, and the block restarts cleanly after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to send |
| lsb_first_i | input | 1 | Data order for the offered byte: 0 = MSB first, 1 = LSB first |
| valid_i | input | 1 | Byte on `data_i` is offered |
| ready_o | output | 1 | Transmitter can take a byte this cycle |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | A frame is being sent |

## Verification
The functions that meet in the same cycle are the completion of a stop bit and the acceptance of the next byte. The bench provokes this by issuing requests back to back, so `valid_i` is already high when the stop bit ends. A scoreboard checks every bit period of both frames, and an idle sample is taken in the gap. This judges whether the stop bit keeps its full length and the next start bit begins cleanly.

A second collision is a reset that lands in the middle of a data bit. It is checked at the ports immediately, and again through a frame sent after release.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } sft_state_e;

  // start + stop bits around the data field
  localparam int unsigned FRAME_OVERHEAD = 2;
endpackage

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
  parameter int unsigned BIT_CYCLES = 3255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic bit_end_o
);
  localparam int unsigned CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  assign bit_end_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sft_frame_shifter.sv
module sft_frame_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              lsb_first_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              line_o
);
  localparam int unsigned FW = DATA_W + sft_pkg::FRAME_OVERHEAD;

  logic [DATA_W-1:0] ordered;
  logic [FW-1:0]     sh_q;

  // ordered[0] goes out first
  for (genvar i = 0; i < DATA_W; i++) begin : g_order
    assign ordered[i] = lsb_first_i ? data_i[i] : data_i[DATA_W-1-i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (load_i)  sh_q <= {1'b1, ordered, 1'b0};
    else if (shift_i) sh_q <= {1'b1, sh_q[FW-1:1]};
  end

  assign line_o = sh_q[0];
endmodule

// File: rtl/sft_ctrl.sv
module sft_ctrl #(
  parameter int unsigned FRAME_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_end_i,
  output logic ready_o,
  output logic busy_o,
  output logic load_o
);
  import sft_pkg::*;

  localparam int unsigned IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  sft_state_e    state_q;
  logic [IW-1:0] idx_q;

  assign ready_o = (state_q == ST_IDLE);
  assign busy_o  = (state_q == ST_SEND);
  assign load_o  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_SEND;
          idx_q   <= '0;
        end
        ST_SEND: if (bit_end_i) begin
          if (idx_q == LAST_IDX) state_q <= ST_IDLE;
          else                   idx_q   <= idx_q + IW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned BAUD   = 38_400,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              lsb_first_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o,
  output logic              busy_o
);
  localparam int unsigned BIT_CYCLES = (CLK_HZ / BAUD > 0) ? CLK_HZ / BAUD : 1;
  localparam int unsigned FRAME_BITS = DATA_W + sft_pkg::FRAME_OVERHEAD;

  logic load;
  logic bit_end;

  sft_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .bit_end_i (bit_end),
    .ready_o   (ready_o),
    .busy_o    (busy_o),
    .load_o    (load)
  );

  sft_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_o),
    .restart_i (load),
    .bit_end_o (bit_end)
  );

  sft_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .lsb_first_i (lsb_first_i),
    .data_i      (data_i),
    .shift_i     (bit_end),
    .line_o      (tx_o)
  );
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk #(
  parameter int unsigned BIT_CYCLES = 3255,
  parameter int unsigned FRAME_BITS = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic tx_o,
  input logic busy_o
);
  int unsigned ph_q;
  int unsigned len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 0;
      len_q <= 0;
    end else if (valid_i && ready_o) begin
      ph_q  <= 0;
      len_q <= 0;
    end else if (busy_o) begin
      ph_q  <= (ph_q == BIT_CYCLES - 1) ? 0 : ph_q + 1;
      len_q <= len_q + 1;
    end
  end

  // R1
  idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  // R2
  start_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> busy_o && !tx_o && !ready_o);

  // R2
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && (ph_q != 0) |-> $stable(tx_o));

  // R5
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (len_q == FRAME_BITS * BIT_CYCLES) && $past(tx_o));
endmodule

bind serial_frame_tx serial_frame_tx_chk #(
  .BIT_CYCLES(BIT_CYCLES),
  .FRAME_BITS(FRAME_BITS)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .tx_o    (tx_o),
  .busy_o  (busy_o)
);

// File: tb/serial_frame_tx_tb_top.sv
`timescale 1ns/1ps
module serial_frame_tx_tb_top;
  localparam int unsigned DIV = 5;
  localparam int unsigned NB  = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic       lsb_first_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       ready_o, tx_o, busy_o;

  always #4 clk_i = ~clk_i;

  serial_frame_tx #(.CLK_HZ(40), .BAUD(8), .DATA_W(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .lsb_first_i(lsb_first_i),
    .valid_i(valid_i), .ready_o(ready_o), .tx_o(tx_o), .busy_o(busy_o)
  );

  typedef struct packed { logic [7:0] b; logic lsb; } item_t;
  item_t exp_q[$];
  int vectors = 0;
  int errs = 0;
  bit mon_on = 1'b1;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic exp_bit(input item_t it, input int k);
    if (k == 0)      return 1'b0;
    if (k == NB - 1) return 1'b1;
    return it.lsb ? it.b[k-1] : it.b[8-k];
  endfunction

  // driver: offer byte, record expectation at acceptance, then scramble inputs (R7)
  task automatic send(input logic [7:0] b, input logic lsb);
    @(negedge clk_i);
    valid_i = 1'b1; data_i = b; lsb_first_i = lsb;
    while (!ready_o) @(negedge clk_i);
    @(posedge clk_i);
    exp_q.push_back('{b: b, lsb: lsb});
    @(negedge clk_i);
    valid_i = 1'b0; data_i = ~b; lsb_first_i = ~lsb;
  endtask

  // monitor / scoreboard
  initial begin : monitor
    forever begin
      @(negedge clk_i);
      if (rst_ni && busy_o && mon_on) begin : frame
        item_t it;
        logic  e;
        int    bad;
        int    rdy_bad;
        int    seen;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "frame without acceptance", 1, 0);
          while (busy_o) @(negedge clk_i);
        end else begin
          it = exp_q.pop_front();
          rdy_bad = 0;
          for (int k = 0; k < NB; k++) begin
            e = exp_bit(it, k);
            bad = 0;
            seen = 0;
            for (int s = 0; s < DIV; s++) begin
              if (k != 0 || s != 0) @(negedge clk_i);
              if (tx_o !== e) begin bad++; seen = tx_o; end
              if (ready_o !== 1'b0) rdy_bad++;
            end
            if (k == 0)           chk(bad == 0, "R2", "start bit", seen, e);
            else if (k == NB - 1) chk(bad == 0, "R5", "stop bit", seen, e);
            else if (it.lsb)      chk(bad == 0, "R4", $sformatf("lsb-first bit %0d", k), seen, e);
            else                  chk(bad == 0, "R3", $sformatf("msb-first bit %0d", k), seen, e);
          end
          chk(rdy_bad == 0, "R6", "ready low during frame", rdy_bad, 0);
          @(negedge clk_i);
          chk(busy_o === 1'b0 && tx_o === 1'b1 && ready_o === 1'b1, "R5",
              "idle after stop (busy,tx,ready)", {busy_o, tx_o, ready_o}, 3'b011);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      vectors++;
      errs++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin : main
    // R8 reset state
    repeat (3) @(negedge clk_i);
    chk(tx_o === 1'b1, "R8", "tx in reset", tx_o, 1);
    chk(busy_o === 1'b0, "R8", "busy in reset", busy_o, 0);
    chk(ready_o === 1'b1, "R8", "ready in reset", ready_o, 1);
    rst_ni = 1'b1;

    // R1 idle, R6 no frame without valid
    data_i = 8'h00;
    repeat (8) @(negedge clk_i);
    chk(tx_o === 1'b1 && busy_o === 1'b0, "R1", "idle line with valid low",
        {tx_o, busy_o}, 2'b10);

    send(8'h41, 1'b0);
    send(8'h41, 1'b1);
    send(8'h90, 1'b0);
    send(8'hA5, 1'b1);
    // back to back: stop-bit end meets next request
    send(8'h00, 1'b0);
    send(8'hFF, 1'b1);
    send(8'h01, 1'b0);
    wait_idle();

    // R6 valid during frame is ignored
    send(8'h3C, 1'b0);
    @(negedge clk_i);
    valid_i = 1'b1; data_i = 8'hC3;
    repeat (20) begin
      @(negedge clk_i);
      chk(ready_o === 1'b0, "R6", "ready while busy", ready_o, 0);
    end
    valid_i = 1'b0;
    wait_idle();
    repeat (3 * DIV) @(negedge clk_i);
    chk(busy_o === 1'b0 && tx_o === 1'b1, "R6", "no extra frame", {busy_o, tx_o}, 2'b01);

    // R8 mid-frame reset
    mon_on = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b1; data_i = 8'h00; lsb_first_i = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (12) @(negedge clk_i);
    chk(tx_o === 1'b0, "R8", "line low before reset", tx_o, 0);
    rst_ni = 1'b0;
    #1;
    chk(tx_o === 1'b1, "R8", "tx after mid-frame reset", tx_o, 1);
    chk(busy_o === 1'b0, "R8", "busy after mid-frame reset", busy_o, 0);
    chk(ready_o === 1'b1, "R8", "ready after mid-frame reset", ready_o, 1);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    send(8'h5A, 1'b1);
    wait_idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule